// File: doc/BRIEF.md
# Accumulator ALU with Conditional Program-Counter Skips

This block is the arithmetic stage of a small accumulator machine. A 3-bit operation code selects one of eight actions. Three of them change the accumulator, using the value held in the memory buffer: subtract, add and clear. The other four ask the sequencer to advance the program counter. One of these advances always. The other three advance only when the accumulator is negative, zero or strictly positive. This is how a program skips the next instruction on a condition.

The sequencer presents the operation, the current accumulator, the buffer word and the current program counter, and raises `en` for one cycle. On the next clock edge the block registers its results. For arithmetic operations it gives the new accumulator value and raises a one-cycle accumulator write strobe. For skip operations that are taken, it gives the incremented program counter and raises a one-cycle increment strobe. The incrementer is a dedicated 12-bit carry chain, kept apart from the data adder. Memory and instruction sequencing stay outside the block.

Top module: `acc_skip_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_out`, `pc_out`, `acc_wr` and `pc_step` become 0 on that edge.
- R2: Operation code 3'b001 with `en` high gives `acc_out = acc_in - mbr_in` modulo 2^16 one cycle later, with `acc_wr` high for that cycle.
- R3: Operation code 3'b010 with `en` high gives `acc_out = acc_in + mbr_in` modulo 2^16 one cycle later, with `acc_wr` high.
- R4: Operation code 3'b011 with `en` high gives `acc_out = 0` one cycle later, with `acc_wr` high.
- R5: Operation code 3'b100 with `en` high always raises `pc_step` one cycle later, with `pc_out = pc_in + 1`. The count wraps from 12'hFFF to 12'h000.
- R6: Operation code 3'b101 raises `pc_step` and gives `pc_out = pc_in + 1` only when bit 15 of `acc_in` is set (two's-complement negative).
- R7: Operation code 3'b110 raises `pc_step` and gives `pc_out = pc_in + 1` only when `acc_in` is zero.
- R8: Operation code 3'b111 raises `pc_step` and gives `pc_out = pc_in + 1` only when `acc_in` is nonzero with bit 15 clear.
- R9: Operation code 3'b000, a skip whose condition fails, or `en` low leaves both strobes low on the next cycle. In those cases `acc_out` and `pc_out` keep their previous values. Arithmetic codes also leave `pc_out` unchanged, and skip codes leave `acc_out` unchanged.
- R10: `acc_wr` and `pc_step` are never high in the same cycle, and each is high only in the cycle after an edge that sampled `en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Perform the operation on this edge |
| op | input | 3 | Operation code |
| acc_in | input | 16 | Current accumulator value |
| mbr_in | input | 16 | Memory buffer operand |
| pc_in | input | 12 | Current program counter |
| acc_out | output | 16 | Registered next accumulator value |
| acc_wr | output | 1 | One-cycle accumulator write strobe |
| pc_out | output | 12 | Registered incremented program counter |
| pc_step | output | 1 | One-cycle program-counter increment strobe |

## Verification
Every piece of internal state in this block sits in the four output registers, so a fault shows up at the ports in the cycle right after the operation is sampled. A wrong condition decode raises or drops `pc_step` against the sign and zero state of `acc_in`. A wrong hold path alters `acc_out` or `pc_out` on a cycle that should leave them alone. The boundary words 16'h0000, 16'h7FFF, 16'h8000 and 16'hFFFF separate the three skip conditions, and a counter of 12'hFFF exposes a broken carry chain at the wrap.

// File: rtl/acc_skip_pkg.sv
package acc_skip_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'b000,
        OP_SUB    = 3'b001,
        OP_ADD    = 3'b010,
        OP_CLR    = 3'b011,
        OP_STEP   = 3'b100,
        OP_SKNEG  = 3'b101,
        OP_SKZERO = 3'b110,
        OP_SKPOS  = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        COND_ALWAYS = 2'd0,
        COND_NEG    = 2'd1,
        COND_ZERO   = 2'd2,
        COND_POS    = 2'd3
    } cond_e;

    typedef struct packed {
        logic  arith;
        logic  skip;
        cond_e cond;
    } alu_ctl_t;

    function automatic alu_ctl_t decode_op(alu_op_e op);
        alu_ctl_t c;
        c.arith = (op == OP_SUB) || (op == OP_ADD) || (op == OP_CLR);
        c.skip  = op[2];
        unique case (op)
            OP_SKNEG:  c.cond = COND_NEG;
            OP_SKZERO: c.cond = COND_ZERO;
            OP_SKPOS:  c.cond = COND_POS;
            default:   c.cond = COND_ALWAYS;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_arith.sv
module acc_arith
    import acc_skip_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_SUB:  y = a - b;
            OP_ADD:  y = a + b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/skip_eval.sv
module skip_eval
    import acc_skip_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  cond_e             cond,
    input  logic [DATA_W-1:0] acc,
    output logic              take
);
    logic is_neg;
    logic is_zero;

    assign is_neg  = acc[DATA_W-1];
    assign is_zero = (acc == '0);

    always_comb begin
        unique case (cond)
            COND_NEG:  take = is_neg;
            COND_ZERO: take = is_zero;
            COND_POS:  take = !is_neg && !is_zero;
            default:   take = 1'b1;
        endcase
    end
endmodule

// File: rtl/pc_incr.sv
module pc_incr #(
    parameter int PC_W = 12
) (
    input  logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] pc_plus
);
    logic [PC_W:0] carry;

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < PC_W; i++) begin : g_bit
        assign pc_plus[i]  = pc[i] ^ carry[i];
        assign carry[i+1]  = pc[i] & carry[i];
    end
endmodule

// File: rtl/acc_skip_alu.sv
module acc_skip_alu
    import acc_skip_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PC_W   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] mbr_in,
    input  logic [PC_W-1:0]   pc_in,
    output logic [DATA_W-1:0] acc_out,
    output logic              acc_wr,
    output logic [PC_W-1:0]   pc_out,
    output logic              pc_step
);
    alu_op_e           op_q;
    alu_ctl_t          ctl;
    logic [DATA_W-1:0] arith_y;
    logic              cond_ok;
    logic [PC_W-1:0]   pc_plus;
    logic              do_wr;
    logic              do_step;

    assign op_q = alu_op_e'(op);
    assign ctl  = decode_op(op_q);

    acc_arith #(.DATA_W(DATA_W)) u_arith (
        .op (op_q),
        .a  (acc_in),
        .b  (mbr_in),
        .y  (arith_y)
    );

    skip_eval #(.DATA_W(DATA_W)) u_skip (
        .cond (ctl.cond),
        .acc  (acc_in),
        .take (cond_ok)
    );

    pc_incr #(.PC_W(PC_W)) u_pcinc (
        .pc      (pc_in),
        .pc_plus (pc_plus)
    );

    assign do_wr   = en && ctl.arith;
    assign do_step = en && ctl.skip && cond_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_out <= '0;
            pc_out  <= '0;
            acc_wr  <= 1'b0;
            pc_step <= 1'b0;
        end else begin
            acc_wr  <= do_wr;
            pc_step <= do_step;
            if (do_wr) begin
                acc_out <= arith_y;
            end
            if (do_step) begin
                pc_out <= pc_plus;
            end
        end
    end
endmodule

// File: rtl/acc_skip_alu_chk.sv
module acc_skip_alu_chk #(
    parameter int DATA_W = 16,
    parameter int PC_W   = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [2:0]        op,
    input logic [DATA_W-1:0] acc_in,
    input logic [PC_W-1:0]   pc_in,
    input logic [DATA_W-1:0] acc_out,
    input logic              acc_wr,
    input logic [PC_W-1:0]   pc_out,
    input logic              pc_step
);
    // R10
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({acc_wr, pc_step}));

    // R10
    strobe_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_wr || pc_step) |-> $past(en));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(en)) |->
            (!acc_wr && !pc_step && $stable(acc_out) && $stable(pc_out)));

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en) && $past(op) == 3'b011) |->
            (acc_wr && acc_out == '0));

    // R5
    step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en) && $past(op) == 3'b100) |->
            (pc_step && pc_out == PC_W'($past(pc_in) + 1'b1)));

    // R7
    zero_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en) && $past(op) == 3'b110) |->
            (pc_step == ($past(acc_in) == '0)));
endmodule

bind acc_skip_alu acc_skip_alu_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .op      (op),
    .acc_in  (acc_in),
    .pc_in   (pc_in),
    .acc_out (acc_out),
    .acc_wr  (acc_wr),
    .pc_out  (pc_out),
    .pc_step (pc_step)
);

// File: tb/sim_acc_skip_alu.sv
`timescale 1ns/1ps
module sim_acc_skip_alu;
    localparam int DW = 16;
    localparam int PW = 12;

    typedef struct {
        logic [DW-1:0] acc;
        logic          wr;
        logic [PW-1:0] pc;
        logic          step;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic [2:0]    op = 3'b000;
    logic [DW-1:0] acc_in = '0;
    logic [DW-1:0] mbr_in = '0;
    logic [PW-1:0] pc_in = '0;
    logic [DW-1:0] acc_out;
    logic          acc_wr;
    logic [PW-1:0] pc_out;
    logic          pc_step;

    int total = 0;
    int bad = 0;
    bit done = 0;
    exp_t sb[$];
    logic [DW-1:0] m_acc = '0;
    logic [PW-1:0] m_pc = '0;

    always #10 clk = ~clk;

    acc_skip_alu #(.DATA_W(DW), .PC_W(PW)) u0 (
        .clk(clk), .rst(rst), .en(en), .op(op), .acc_in(acc_in),
        .mbr_in(mbr_in), .pc_in(pc_in), .acc_out(acc_out), .acc_wr(acc_wr),
        .pc_out(pc_out), .pc_step(pc_step)
    );

    task automatic compare(exp_t e);
        total++;
        if (acc_out !== e.acc || acc_wr !== e.wr || pc_out !== e.pc || pc_step !== e.step) begin
            bad++;
            $display("FAIL %s: acc=%h wr=%b pc=%h step=%b expected acc=%h wr=%b pc=%h step=%b",
                     e.tag, acc_out, acc_wr, pc_out, pc_step, e.acc, e.wr, e.pc, e.step);
        end
    endtask

    task automatic drive(input logic e_in, input logic [2:0] o, input logic [DW-1:0] a,
                         input logic [DW-1:0] b, input logic [PW-1:0] p, input string tag);
        exp_t x;
        logic take;
        @(negedge clk);
        en = e_in; op = o; acc_in = a; mbr_in = b; pc_in = p;
        x.wr = 1'b0; take = 1'b0;
        if (e_in) begin
            case (o)
                3'b001: begin m_acc = a - b; x.wr = 1'b1; end
                3'b010: begin m_acc = a + b; x.wr = 1'b1; end
                3'b011: begin m_acc = '0;    x.wr = 1'b1; end
                3'b100: take = 1'b1;
                3'b101: take = a[DW-1];
                3'b110: take = (a == '0);
                3'b111: take = !a[DW-1] && (a != '0);
                default: ;
            endcase
        end
        if (take) m_pc = p + 1'b1;
        x.acc = m_acc; x.pc = m_pc; x.step = take; x.tag = tag;
        sb.push_back(x);
    endtask

    always @(posedge clk) begin
        #1;
        if (!rst && sb.size() > 0) compare(sb.pop_front());
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        begin
            exp_t r;
            r.acc = '0; r.wr = 0; r.pc = '0; r.step = 0; r.tag = "R1 reset";
            compare(r);
        end
        @(negedge clk);
        rst = 1'b0;
        // R2 subtract with borrow wrap
        drive(1, 3'b001, 16'h0005, 16'h0007, 12'h010, "R2 sub wrap");
        drive(1, 3'b001, 16'h1234, 16'h0234, 12'h010, "R2 sub");
        // R3 add with wrap and sign crossing
        drive(1, 3'b010, 16'hFFFF, 16'h0002, 12'h010, "R3 add wrap");
        drive(1, 3'b010, 16'h7FFF, 16'h0001, 12'h010, "R3 add 7FFF");
        // R4 clear
        drive(1, 3'b011, 16'hABCD, 16'h1111, 12'h010, "R4 clear");
        // R5 unconditional, including wrap
        drive(1, 3'b100, 16'h0000, 16'h0000, 12'h123, "R5 step");
        drive(1, 3'b100, 16'h8000, 16'h0000, 12'hFFF, "R5 step wrap");
        // R6 negative skip
        drive(1, 3'b101, 16'h8000, 16'h0000, 12'h040, "R6 neg taken");
        drive(1, 3'b101, 16'h0001, 16'h0000, 12'h050, "R6 neg not taken");
        drive(1, 3'b101, 16'h0000, 16'h0000, 12'h050, "R6 zero not neg");
        // R7 zero skip
        drive(1, 3'b110, 16'h0000, 16'h0000, 12'h060, "R7 zero taken");
        drive(1, 3'b110, 16'h0001, 16'h0000, 12'h070, "R7 nonzero");
        drive(1, 3'b110, 16'h8000, 16'h0000, 12'h070, "R7 negative");
        // R8 positive skip
        drive(1, 3'b111, 16'h7FFF, 16'h0000, 12'h080, "R8 pos taken");
        drive(1, 3'b111, 16'h0001, 16'h0000, 12'h090, "R8 one taken");
        drive(1, 3'b111, 16'h0000, 16'h0000, 12'h0A0, "R8 zero not pos");
        drive(1, 3'b111, 16'hFFFF, 16'h0000, 12'h0A0, "R8 neg not pos");
        // R9 no-op and disabled cycles hold outputs
        drive(1, 3'b000, 16'h5555, 16'h1111, 12'h333, "R9 nop hold");
        drive(0, 3'b010, 16'h5555, 16'h1111, 12'h333, "R9 en low add");
        drive(0, 3'b100, 16'h5555, 16'h1111, 12'h333, "R9 en low step");
        // R10 alternating strobes back to back
        for (int i = 0; i < 8; i++) begin
            drive(1, 3'(i), 16'(i * 16'h2111), 16'h0303, 12'(i * 12'h1F1), "R10 sweep");
        end
        drive(0, 3'b000, '0, '0, '0, "R10 tail");
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end
endmodule